// File: doc/BRIEF.md
# Event-to-Interrupt Aggregation Controller

This block gathers single-cycle event pulses from up to 96 sources into three 32-bit pending words. Each event arrives as a 7-bit code. Bits 6:5 of the code choose the pending word and bits 4:0 choose the bit inside that word. A pending bit stays set until software clears it by writing a one to it.

Three mask banks each hold one 32-bit enable word per pending word. Each bank feeds its own level-sensitive interrupt line:

- Bank A drives `irq_hi`, the highest priority.
- Bank B drives `irq_mid`.
- Bank C drives `irq_lo`, the lowest priority.

A line is high while any pending bit is enabled in its bank, in any of the three words.

Software uses a small byte-addressed register bus. Write data is taken on `bus_wr`. Read data is combinational from `bus_addr`.

| Registers | Byte offsets |
|---|---|
| Pending words | 0x00, 0x04, 0x08 |
| Bank A masks | 0x10, 0x14, 0x18 |
| Bank B masks | 0x20, 0x24, 0x28 |
| Bank C masks | 0x30, 0x34, 0x38 |

Top module: `evt_irq_aggregator`

## Requirements
- R1: After reset, every pending and mask register reads 0 and all three interrupt outputs are low.
- R2: An event with `evt_valid` high and code bits 6:5 equal to w (0..2) sets bit code[4:0] of pending word w. The bit is readable at byte offset 4*w from the cycle after the pulse.
- R3: A pending bit stays set through idle cycles and reads, and changes only when a one is written to it.
- R4: A write to pending offset 4*w clears exactly the bits that are 1 in the write data and leaves all other bits unchanged. Writing 0 changes nothing.
- R5: The mask for bank A, B or C and word w is written and read back at byte offset 0x10, 0x20 or 0x30 plus 4*w.
- R6: Bank A drives `irq_hi`, bank B drives `irq_mid` and bank C drives `irq_lo`. Each output is high when, for some word w, pending word w AND that bank's mask word w is nonzero.
- R7: Clearing one pending bit leaves an output high while another enabled pending bit remains in any word. The output goes low only when no enabled pending bit is left in any word.
- R8: Reading a register has no side effect: pending contents and the outputs are unchanged after reads.
- R9: A mask write that enables an already pending bit raises the output in the cycle after the write. A mask write that disables the last enabled pending bit lowers the output in the cycle after the write.
- R10: If an event and a clear write hit the same bit in the same cycle, the bit stays set. Other bits named in the clear are still cleared.
- R11: An event code with bits 6:5 equal to 3 changes nothing. A write to word slot 3 of any group, or to an address with bits 1:0 nonzero, changes nothing. Reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event pulse qualifier |
| evt_code | input | 7 | Event code: [6:5] word, [4:0] bit |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data (clear mask for pending words) |
| bus_rdata | output | 32 | Combinational read data |
| irq_hi | output | 1 | Interrupt output of mask bank A |
| irq_mid | output | 1 | Interrupt output of mask bank B |
| irq_lo | output | 1 | Interrupt output of mask bank C |

## Verification
An event pulse and a write-one-to-clear can land on the same pending word in the same clock cycle. The bench provokes this by raising `evt_valid` for bit 7 of word 0 while writing 0x81 to offset 0. Bit 0 was set beforehand. The pending word is then judged by reading it back: it must hold 0x80, with the event's bit surviving and the other cleared bit gone.

// File: rtl/evt_irq_aggregator.sv
module evt_irq_aggregator #(
  parameter int W  = 32,
  parameter int NW = 3,
  localparam int BW = $clog2(W),
  localparam int CW = 2 + BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_valid,
  input  logic [CW-1:0] evt_code,
  input  logic          bus_wr,
  input  logic [5:0]    bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          irq_hi,
  output logic          irq_mid,
  output logic          irq_lo
);

  logic [W-1:0]    pend [NW];
  logic [W-1:0]    mask [3][NW];
  logic [NW*W-1:0] pend_flat;
  logic [NW-1:0]   hits [3];

  wire       aligned = bus_addr[1:0] == 2'd0;
  wire [1:0] grp     = bus_addr[5:4];
  wire [1:0] wsel    = bus_addr[3:2];

  for (genvar w = 0; w < NW; w++) begin : g_word
    wire          evt_here = evt_valid && evt_code[CW-1:BW] == 2'(w);
    wire          wr_here  = bus_wr && aligned && wsel == 2'(w);
    wire [W-1:0]  set_v    = evt_here ? (W'(1) << evt_code[BW-1:0]) : '0;
    wire [W-1:0]  clr_v    = (wr_here && grp == 2'd0) ? bus_wdata : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) pend[w] <= '0;
      else        pend[w] <= (pend[w] & ~clr_v) | set_v;
    end

    assign pend_flat[w*W +: W] = pend[w];

    for (genvar b = 0; b < 3; b++) begin : g_bank
      always_ff @(posedge clk) begin
        if (!rst_n)                          mask[b][w] <= '0;
        else if (wr_here && grp == 2'(b+1))  mask[b][w] <= bus_wdata;
      end
      assign hits[b][w] = |(pend[w] & mask[b][w]);
    end
  end

  assign irq_hi  = |hits[0];
  assign irq_mid = |hits[1];
  assign irq_lo  = |hits[2];

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < NW; w++) begin
      if (aligned && wsel == 2'(w)) begin
        case (grp)
          2'd0:    bus_rdata = pend_flat[w*W +: W];
          2'd1:    bus_rdata = mask[0][w];
          2'd2:    bus_rdata = mask[1][w];
          default: bus_rdata = mask[2][w];
        endcase
      end
    end
  end

endmodule

// File: rtl/evt_irq_aggregator_chk.sv
module evt_irq_aggregator_chk #(
  parameter int W  = 32,
  parameter int NW = 3,
  localparam int BW = $clog2(W),
  localparam int CW = 2 + BW
) (
  input logic            clk,
  input logic            rst_n,
  input logic            evt_valid,
  input logic [CW-1:0]   evt_code,
  input logic            bus_wr,
  input logic [5:0]      bus_addr,
  input logic [W-1:0]    bus_wdata,
  input logic            irq_hi,
  input logic            irq_mid,
  input logic            irq_lo,
  input logic [NW*W-1:0] pend_flat
);

  localparam logic [NW*W-1:0] ONE = {{(NW*W-1){1'b0}}, 1'b1};

  wire clr_wr = bus_wr && bus_addr[1:0] == 2'd0 && bus_addr[5:4] == 2'd0 &&
                int'(bus_addr[3:2]) < NW;

  p_reset_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (pend_flat == '0 && !irq_hi && !irq_mid && !irq_lo));

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && int'(evt_code[CW-1:BW]) < NW) |=>
      |(pend_flat & (ONE << ($past(evt_code[CW-1:BW]) * W + $past(evt_code[BW-1:0])))));

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((pend_flat & $past(pend_flat)) == $past(pend_flat)));

  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !evt_valid) |=>
      (W'(pend_flat >> ($past(bus_addr[3:2]) * W)) ==
       (W'($past(pend_flat) >> ($past(bus_addr[3:2]) * W)) & ~$past(bus_wdata))));

  p_hi_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_hi) |-> ($past(evt_valid) || $past(bus_wr)));
  p_mid_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_mid) |-> ($past(evt_valid) || $past(bus_wr)));
  p_lo_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_lo) |-> ($past(evt_valid) || $past(bus_wr)));

  p_hi_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_hi) |-> $past(bus_wr));
  p_mid_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_mid) |-> $past(bus_wr));
  p_lo_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_lo) |-> $past(bus_wr));

  p_evt_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && clr_wr && evt_code[CW-1:BW] == bus_addr[3:2]) |=>
      |(pend_flat & (ONE << ($past(evt_code[CW-1:BW]) * W + $past(evt_code[BW-1:0])))));

  p_bad_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_code[CW-1:BW] == 2'd3 && !bus_wr) |=> $stable(pend_flat));

endmodule

bind evt_irq_aggregator evt_irq_aggregator_chk #(.W(W), .NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .irq_hi(irq_hi), .irq_mid(irq_mid), .irq_lo(irq_lo), .pend_flat(pend_flat)
);

// File: tb/evt_irq_aggregator_test.sv
module evt_irq_aggregator_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [6:0]  evt_code = '0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_hi, irq_mid, irq_lo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evt_irq_aggregator uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_hi(irq_hi), .irq_mid(irq_mid), .irq_lo(irq_lo)
  );

  typedef struct packed {
    logic [6:0]  code;
    logic [5:0]  addr;
    logic [31:0] val;
  } vec_t;

  localparam vec_t TBL [7] = '{
    '{7'h00, 6'd0, 32'h0000_0001},
    '{7'h1F, 6'd0, 32'h8000_0000},
    '{7'h20, 6'd4, 32'h0000_0001},
    '{7'h25, 6'd4, 32'h0000_0020},
    '{7'h40, 6'd8, 32'h0000_0001},
    '{7'h5F, 6'd8, 32'h8000_0000},
    '{7'h6A, 6'd0, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic evt(input logic [6:0] c);
    @(negedge clk);
    evt_valid = 1'b1; evt_code = c;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic clear_all();
    for (int w = 0; w < 3; w++) begin
      wr(6'(4*w), 32'hFFFF_FFFF);
      wr(6'(16 + 4*w), 32'h0);
      wr(6'(32 + 4*w), 32'h0);
      wr(6'(48 + 4*w), 32'h0);
    end
  endtask

  function automatic logic [31:0] irqs();
    return {29'd0, irq_hi, irq_mid, irq_lo};
  endfunction

  initial begin : watchdog
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d, d2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 64; a += 4) begin
      rd(6'(a), d);
      check("R1 reset register", d, 32'h0);
    end
    check("R1 reset outputs", irqs(), 32'h0);

    // R2 / R11: event code table
    foreach (TBL[i]) begin
      clear_all();
      evt(TBL[i].code);
      rd(TBL[i].addr, d);
      check("R2 event sets bit", d, TBL[i].val);
    end
    rd(6'd4, d);  check("R11 bad code word1", d, 32'h0);
    rd(6'd8, d);  check("R11 bad code word2", d, 32'h0);

    // R3 / R8: sticky and side-effect-free reads
    clear_all();
    evt(7'h03);
    wr(6'h10, 32'h8);
    repeat (4) @(negedge clk);
    rd(6'd0, d); rd(6'd0, d2);
    check("R3 sticky", d, 32'h8);
    check("R8 repeat read", d2, 32'h8);
    @(negedge clk);
    rd(6'd0, d);
    check("R8 after reads", d, 32'h8);
    check("R8 irq unchanged", irqs(), 32'h4);

    // R4: write-one-to-clear
    clear_all();
    evt(7'h20); evt(7'h21); evt(7'h22);
    wr(6'd4, 32'h5);
    rd(6'd4, d); check("R4 partial clear", d, 32'h2);
    wr(6'd4, 32'h0);
    rd(6'd4, d); check("R4 zero write", d, 32'h2);

    // R5: mask read/write
    wr(6'h18, 32'hA5A5_5A5A);
    wr(6'h20, 32'h1234_5678);
    wr(6'h34, 32'hDEAD_BEEF);
    rd(6'h18, d); check("R5 mask A w2", d, 32'hA5A5_5A5A);
    rd(6'h20, d); check("R5 mask B w0", d, 32'h1234_5678);
    rd(6'h34, d); check("R5 mask C w1", d, 32'hDEAD_BEEF);
    rd(6'h14, d); check("R5 mask A w1 untouched", d, 32'h0);

    // R6 / R7 / R9: routing and deassert rules
    clear_all();
    evt(7'h21);
    check("R6 masked off", irqs(), 32'h0);
    wr(6'h24, 32'h2);
    check("R9 mask enables pending -> mid", irqs(), 32'h2);
    evt(7'h05);
    wr(6'h20, 32'h20);
    wr(6'd4, 32'h2);
    check("R7 still pending elsewhere", irqs(), 32'h2);
    wr(6'd0, 32'h20);
    check("R7 all clear -> low", irqs(), 32'h0);
    evt(7'h45);
    wr(6'h18, 32'h20);
    check("R6 bank A -> hi", irqs(), 32'h4);
    wr(6'h38, 32'h20);
    check("R6 bank C -> lo", irqs(), 32'h5);
    wr(6'h18, 32'h0);
    check("R9 mask disables -> hi low", irqs(), 32'h1);

    // R10: event vs clear in same cycle
    clear_all();
    evt(7'h00);
    @(negedge clk);
    evt_valid = 1'b1; evt_code = 7'h07;
    bus_wr = 1'b1; bus_addr = 6'd0; bus_wdata = 32'h81;
    @(negedge clk);
    evt_valid = 1'b0; bus_wr = 1'b0;
    rd(6'd0, d); check("R10 event wins", d, 32'h80);

    // R11: ignored addresses
    wr(6'h0C, 32'hFFFF_FFFF);
    wr(6'h1C, 32'hFFFF_FFFF);
    wr(6'h11, 32'hFFFF_FFFF);
    rd(6'h0C, d); check("R11 slot3 pending", d, 32'h0);
    rd(6'h1C, d); check("R11 slot3 mask", d, 32'h0);
    rd(6'h10, d); check("R11 misaligned write", d, 32'h0);
    rd(6'd0, d);  check("R11 pending intact", d, 32'h80);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule